// File: doc/BRIEF.md
# Power-On Strap Capture and Shared Clock Pin Router

This block governs a group of dual-use clock pins. While the power-on reset input is low, every pin is an input and its driver is off. The configuration levels applied to the pins by board resistors are sampled once, on the first clock edge after reset is released. From that edge on, the pins are outputs carrying clock signals. The captured levels seed a four-bit frequency code and a 24/48 MHz rate select. Two further straps form a mode code that decides which clock family, link clock or bus clock, drives each of three shared pins.

Each pin has its own enable bit. All enables come up set after power-on reset. A cleared bit holds that pin low while its driver stays on. After capture, the frequency code, the rate select and the enable mask can be overwritten through simple write strobes. The mode code changes only when a new power-on reset captures fresh strap levels. Clock synthesis and pad electrical behaviour are not part of this block. The clock sources arrive as plain inputs and are routed and gated here.

Top module: `strapPinMux`

## Requirements
- R1: While `porN` is low, and in the cycle between its release and the next rising clock edge, `padOe` and `padOut` are all zero.
- R2: On the first rising edge of `clk` with `porN` high, the strap levels on `padIn` are captured, and from that edge on every bit of `padOe` is 1.
- R3: After capture, changes on `padIn` have no effect on `freqSel`, `rateSel` or the shared-pin routing until the next power-on reset.
- R4: Capture loads `freqSel` from `padIn[3:0]` and `rateSel` from `padIn[4]`. With `rateSel`=0, pin 4 carries `clk48Src`; with 1 it carries `clk24Src`.
- R5: The mode code is A=`padIn[5]`, B=`padIn[6]`, and it routes shared pins 6, 7 and 8 (H = `httSrc`, P = `pciSrc`): AB=00 gives H,H,P; 01 gives H,H,H; 10 gives P,P,P; 11 gives H,P,P.
- R6: The enable mask is set to all ones by power-on reset. After capture, an edge with `enWr`=1 loads it from `enWrData`, where bit i controls pin i.
- R7: A pin whose enable bit is 0 drives `padOut` low while its `padOe` stays 1.
- R8: After capture, an edge with `freqWr`=1 loads `rateSel` from `freqWrData[4]` and `freqSel` from `freqWrData[3:0]`. Pin 4 follows the new rate select.
- R9: Pins 0 to 2 carry `refSrc`, pin 3 carries `clk48Src` and pin 5 carries `httSrc`.
- R10: A later power-on reset captures the straps again, clears any written values, and applies the new mode and frequency code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| porN | input | 1 | Power-on reset, active low, asynchronous assert |
| padIn | input | 7 | Sampled pin levels (straps) |
| refSrc | input | 1 | Reference clock source |
| clk48Src | input | 1 | 48 MHz clock source |
| clk24Src | input | 1 | 24 MHz clock source |
| httSrc | input | 1 | Link clock family source |
| pciSrc | input | 1 | Bus clock family source |
| enWr | input | 1 | Enable mask write strobe |
| enWrData | input | 9 | New enable mask |
| freqWr | input | 1 | Frequency field write strobe |
| freqWrData | input | 5 | {rate select, frequency code} |
| padOut | output | 9 | Pin output values |
| padOe | output | 9 | Pin driver enables |
| freqSel | output | 4 | Frequency code |
| rateSel | output | 1 | 1 selects 24 MHz on pin 4, 0 selects 48 MHz |

## Verification
The assertions assume that `porN` is released away from a clock edge and stays high for at least one edge after release. They also assume that writes arriving during the capture cycle are meant to be dropped. The stimulus changes `porN` and every other input one time unit after a rising edge, so capture always sees settled strap levels. The stimulus enters power-on reset several times with different strap patterns so that all four mode codes are covered. Between these resets it moves `padIn` freely, which shows that the captured values hold.

// File: rtl/strapMuxPkg.sv
package strapMuxPkg;

  typedef struct packed {
    logic capture;
    logic driveOn;
  } strapCtl_t;

  typedef enum logic {
    PH_HOLD = 1'b0,
    PH_RUN  = 1'b1
  } phase_t;

  typedef enum logic {
    FAM_HTT = 1'b0,
    FAM_PCI = 1'b1
  } clkFam_t;

  localparam int SHARED_N = 3;

  // mode = {A, B}; slot 0..2 are the three shared pins
  function automatic clkFam_t sharedFamily(input logic [1:0] mode, input int slot);
    clkFam_t fam;
    case (slot)
      0:       fam = (mode == 2'b10) ? FAM_PCI : FAM_HTT;
      1:       fam = mode[1] ? FAM_PCI : FAM_HTT;
      default: fam = (mode == 2'b01) ? FAM_HTT : FAM_PCI;
    endcase
    return fam;
  endfunction

endpackage

// File: rtl/strapCtrl.sv
module strapCtrl
  import strapMuxPkg::*;
(
  input  logic      clk,
  input  logic      porN,
  output strapCtl_t ctl
);

  phase_t phase;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      phase <= PH_HOLD;
    end else if (phase == PH_HOLD) begin
      phase <= PH_RUN;
    end
  end

  assign ctl.capture = porN && (phase == PH_HOLD);
  assign ctl.driveOn = (phase == PH_RUN);

  // R2: one capture strobe per power-on reset, then drivers on
  assert_capture_once_R2: assert property (@(posedge clk) disable iff (!porN)
    ctl.capture |=> (!ctl.capture && ctl.driveOn));

endmodule

// File: rtl/strapDatapath.sv
module strapDatapath
  import strapMuxPkg::*;
#(
  parameter  int REF_N   = 3,
  localparam int FS_W    = REF_N + 1,
  localparam int STRAP_N = FS_W + 3,
  localparam int PIN_N   = STRAP_N + SHARED_N - 1
) (
  input  logic             clk,
  input  logic             porN,
  input  strapCtl_t        ctl,
  input  logic [STRAP_N-1:0] padIn,
  input  logic             enWr,
  input  logic [PIN_N-1:0] enWrData,
  input  logic             freqWr,
  input  logic [FS_W:0]    freqWrData,
  output logic [FS_W-1:0]  freqSel,
  output logic             rateSel,
  output logic [1:0]       modeSel,
  output logic [PIN_N-1:0] enMask
);

  localparam int RATE_BIT = FS_W;
  localparam int MODEA_BIT = FS_W + 1;
  localparam int MODEB_BIT = FS_W + 2;

  logic [FS_W-1:0]  fsReg;
  logic             rateReg;
  logic [1:0]       modeReg;
  logic [PIN_N-1:0] enReg;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      fsReg   <= '0;
      rateReg <= 1'b0;
      modeReg <= 2'b00;
      enReg   <= '1;
    end else begin
      if (ctl.capture) begin
        fsReg   <= padIn[FS_W-1:0];
        rateReg <= padIn[RATE_BIT];
        modeReg <= {padIn[MODEA_BIT], padIn[MODEB_BIT]};
      end else if (ctl.driveOn && freqWr) begin
        {rateReg, fsReg} <= freqWrData;
      end
      if (ctl.driveOn && enWr) begin
        enReg <= enWrData;
      end
    end
  end

  assign freqSel = fsReg;
  assign rateSel = rateReg;
  assign modeSel = modeReg;
  assign enMask  = enReg;

  // R4: seeded fields equal the pin levels present at the capture edge
  assert_seed_R4: assert property (@(posedge clk) disable iff (!porN)
    $past(ctl.capture) |-> (freqSel == $past(padIn[FS_W-1:0]) && rateSel == $past(padIn[RATE_BIT])));

  // R3: captured mode never moves while running
  assert_mode_hold_R3: assert property (@(posedge clk) disable iff (!porN)
    $past(ctl.driveOn) |-> $stable(modeSel));

  // R3: frequency fields move only through a write
  assert_freq_hold_R3: assert property (@(posedge clk) disable iff (!porN)
    ($past(ctl.driveOn) && !$past(freqWr)) |-> ($stable(freqSel) && $stable(rateSel)));

  // R6: enable mask takes the written value
  assert_en_write_R6: assert property (@(posedge clk) disable iff (!porN)
    ($past(enWr) && $past(ctl.driveOn)) |-> (enMask == $past(enWrData)));

endmodule

// File: rtl/pinMux.sv
module pinMux
  import strapMuxPkg::*;
#(
  parameter  int REF_N   = 3,
  localparam int PIN_N   = REF_N + 3 + SHARED_N,
  localparam int PIN_48  = REF_N,
  localparam int PIN_RATE = REF_N + 1,
  localparam int PIN_HTT0 = REF_N + 2,
  localparam int SH_BASE = REF_N + 3
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             driveOn,
  input  logic [PIN_N-1:0] enMask,
  input  logic [1:0]       modeSel,
  input  logic             rateSel,
  input  logic             refSrc,
  input  logic             clk48Src,
  input  logic             clk24Src,
  input  logic             httSrc,
  input  logic             pciSrc,
  output logic [PIN_N-1:0] padOut,
  output logic [PIN_N-1:0] padOe
);

  logic [PIN_N-1:0]    rawClk;
  logic [SHARED_N-1:0] famBits;

  for (genvar r = 0; r < REF_N; r++) begin : gRef
    assign rawClk[r] = refSrc;
  end

  assign rawClk[PIN_48]   = clk48Src;
  assign rawClk[PIN_RATE] = rateSel ? clk24Src : clk48Src;
  assign rawClk[PIN_HTT0] = httSrc;

  for (genvar s = 0; s < SHARED_N; s++) begin : gShared
    assign famBits[s] = (sharedFamily(modeSel, s) == FAM_PCI);
    assign rawClk[SH_BASE+s] = famBits[s] ? pciSrc : httSrc;
  end

  assign padOe  = {PIN_N{driveOn}};
  assign padOut = rawClk & enMask & padOe;

  // R5: routing of shared pins is fixed once running
  assert_route_stable_R5: assert property (@(posedge clk) disable iff (!porN)
    ($past(driveOn) && driveOn) |-> $stable(famBits));

endmodule

// File: rtl/strapPinMux.sv
module strapPinMux
  import strapMuxPkg::*;
#(
  parameter  int REF_N   = 3,
  localparam int FS_W    = REF_N + 1,
  localparam int STRAP_N = FS_W + 3,
  localparam int PIN_N   = REF_N + 3 + SHARED_N
) (
  input  logic               clk,
  input  logic               porN,
  input  logic [STRAP_N-1:0] padIn,
  input  logic               refSrc,
  input  logic               clk48Src,
  input  logic               clk24Src,
  input  logic               httSrc,
  input  logic               pciSrc,
  input  logic               enWr,
  input  logic [PIN_N-1:0]   enWrData,
  input  logic               freqWr,
  input  logic [FS_W:0]      freqWrData,
  output logic [PIN_N-1:0]   padOut,
  output logic [PIN_N-1:0]   padOe,
  output logic [FS_W-1:0]    freqSel,
  output logic               rateSel
);

  strapCtl_t        ctl;
  logic [1:0]       modeSel;
  logic [PIN_N-1:0] enMask;

  strapCtrl u_ctrl (
    .clk (clk),
    .porN(porN),
    .ctl (ctl)
  );

  strapDatapath #(.REF_N(REF_N)) u_dp (
    .clk       (clk),
    .porN      (porN),
    .ctl       (ctl),
    .padIn     (padIn),
    .enWr      (enWr),
    .enWrData  (enWrData),
    .freqWr    (freqWr),
    .freqWrData(freqWrData),
    .freqSel   (freqSel),
    .rateSel   (rateSel),
    .modeSel   (modeSel),
    .enMask    (enMask)
  );

  pinMux #(.REF_N(REF_N)) u_mux (
    .clk     (clk),
    .porN    (porN),
    .driveOn (ctl.driveOn),
    .enMask  (enMask),
    .modeSel (modeSel),
    .rateSel (rateSel),
    .refSrc  (refSrc),
    .clk48Src(clk48Src),
    .clk24Src(clk24Src),
    .httSrc  (httSrc),
    .pciSrc  (pciSrc),
    .padOut  (padOut),
    .padOe   (padOe)
  );

  // R1: drivers stay off through the capture cycle
  assert_drivers_off_R1: assert property (@(posedge clk) disable iff (!porN)
    ctl.capture |-> (padOe == '0 && padOut == '0));

  // R2: every driver is on after the capture edge
  assert_drivers_on_R2: assert property (@(posedge clk) disable iff (!porN)
    $past(ctl.capture) |-> (padOe == '1));

  // R7: a cleared enable bit forces its pin low
  for (genvar p = 0; p < PIN_N; p++) begin : gEnChk
    assert_disabled_low_R7: assert property (@(posedge clk) disable iff (!porN)
      ($past(enWr) && $past(ctl.driveOn) && !$past(enWrData[p])) |-> !padOut[p]);
  end

endmodule

// File: tb/sim_strapPinMux.sv
module sim_strapPinMux;

  logic clk = 1'b0;
  logic porN = 1'b1;
  logic [6:0] padIn = 7'b1110111;
  logic refSrc = 1'b1, clk48Src = 1'b1, clk24Src = 1'b0, httSrc = 1'b1, pciSrc = 1'b0;
  logic enWr = 1'b0, freqWr = 1'b0;
  logic [8:0] enWrData = '0;
  logic [4:0] freqWrData = '0;
  logic [8:0] padOut, padOe;
  logic [3:0] freqSel;
  logic rateSel;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  strapPinMux u0 (
    .clk(clk), .porN(porN), .padIn(padIn),
    .refSrc(refSrc), .clk48Src(clk48Src), .clk24Src(clk24Src),
    .httSrc(httSrc), .pciSrc(pciSrc),
    .enWr(enWr), .enWrData(enWrData), .freqWr(freqWr), .freqWrData(freqWrData),
    .padOut(padOut), .padOe(padOe), .freqSel(freqSel), .rateSel(rateSel)
  );

  // behavioural reference
  bit         mRun  = 1'b0;
  logic [3:0] mFs   = '0;
  logic       mRate = 1'b0;
  logic [1:0] mMode = 2'b00;
  logic [8:0] mEn   = '1;

  always @(posedge clk or negedge porN) begin
    if (!porN) begin
      mRun = 1'b0; mFs = '0; mRate = 1'b0; mMode = 2'b00; mEn = '1;
    end else if (!mRun) begin
      mFs = padIn[3:0]; mRate = padIn[4]; mMode = {padIn[5], padIn[6]}; mRun = 1'b1;
    end else begin
      if (enWr) mEn = enWrData;
      if (freqWr) {mRate, mFs} = freqWrData;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      logic [8:0] v;
      v[2:0] = {3{refSrc}};
      v[3] = clk48Src;
      v[4] = mRate ? clk24Src : clk48Src;
      v[5] = httSrc;
      case (mMode)
        2'b00:   v[8:6] = {pciSrc, httSrc, httSrc};
        2'b01:   v[8:6] = {httSrc, httSrc, httSrc};
        2'b10:   v[8:6] = {pciSrc, pciSrc, pciSrc};
        default: v[8:6] = {pciSrc, pciSrc, httSrc};
      endcase
      v = mRun ? (v & mEn) : 9'd0;
      check("R2 model padOe", 32'(padOe), mRun ? 32'h1FF : 32'h0);
      check("R5/R7 model padOut", 32'(padOut), 32'(v));
      if (mRun) begin
        check("R4/R8 model freqSel", 32'(freqSel), 32'(mFs));
        check("R4/R8 model rateSel", 32'(rateSel), 32'(mRate));
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic look();
    @(negedge clk); #1;
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
    end
  end

  initial begin
    #1 porN = 1'b0;
    repeat (3) tick();
    look();
    check("R1 oe in reset", 32'(padOe), 32'h0);
    check("R1 out in reset", 32'(padOut), 32'h0);
    tick(); porN = 1'b1;
    look();
    check("R1 oe before capture edge", 32'(padOe), 32'h0);
    tick();
    look();
    check("R2 oe after capture", 32'(padOe), 32'h1FF);
    check("R4 freq seed", 32'(freqSel), 32'h7);
    check("R4 rate seed", 32'(rateSel), 32'h1);
    check("R4 pin4 carries 24", 32'(padOut[4]), 32'(clk24Src));
    check("R9 fixed pins", 32'(padOut[5:0]), 32'b101111);
    check("R5 mode11 shared", 32'(padOut[8:6]), 32'b001);
    tick(); padIn = 7'b0000000; httSrc = 1'b0; pciSrc = 1'b1;
    tick(); tick();
    look();
    check("R3 freq held", 32'(freqSel), 32'h7);
    check("R3 routing held", 32'(padOut[8:6]), 32'b110);
    for (int k = 0; k < 32; k++) begin
      tick();
      {refSrc, clk48Src, clk24Src, httSrc, pciSrc} = 5'(k);
      padIn = 7'(k * 5);
    end
    tick(); enWr = 1'b1; enWrData = 9'b010101010;
    {refSrc, clk48Src, clk24Src, httSrc, pciSrc} = 5'b11111;
    tick(); enWr = 1'b0;
    look();
    check("R7 disabled pins low", 32'(padOut), 32'h0AA);
    check("R7 oe kept", 32'(padOe), 32'h1FF);
    check("R6 mask loaded", 32'(padOut[1]), 32'h1);
    tick(); enWr = 1'b1; enWrData = '1; freqWr = 1'b1; freqWrData = 5'b01010;
    clk24Src = 1'b0;
    tick(); enWr = 1'b0; freqWr = 1'b0;
    look();
    check("R8 freq written", 32'(freqSel), 32'hA);
    check("R8 rate written", 32'(rateSel), 32'h0);
    check("R8 pin4 carries 48", 32'(padOut[4]), 32'h1);
    tick(); enWr = 1'b1; enWrData = 9'b000000000;
    tick(); enWr = 1'b0;
    for (int m = 0; m < 3; m++) begin
      logic [1:0] ab;
      logic [2:0] expSh;
      ab = 2'(m);
      tick(); porN = 1'b0;
      {refSrc, clk48Src, clk24Src, httSrc, pciSrc} = 5'b11110;
      padIn = {ab[0], ab[1], 1'b1, 4'(m + 3)};
      look();
      check("R1 oe off on re-reset", 32'(padOe), 32'h0);
      tick(); porN = 1'b1;
      tick();
      look();
      case (ab)
        2'b00:   expSh = 3'b011;
        2'b01:   expSh = 3'b111;
        default: expSh = 3'b000;
      endcase
      check("R10 freq recaptured", 32'(freqSel), 32'(m + 3));
      check("R6 enables reset to ones", 32'(padOut[5:0]), 32'h3F);
      check("R5 shared routing", 32'(padOut[8:6]), 32'(expSh));
    end
    tick();
    summary();
  end

endmodule